// File: doc/BRIEF.md
# Dual Chip-Select Bus Strobe Decoder

This block connects an asynchronous processor bus to a sampled-data core. Four bus lines enter it: two chip selects of opposite polarity, a read line and a write line. The block samples them on its own clock and forms two internal strobes. The read strobe takes one word from a sample FIFO and drives it to the bus through a tristate driver, whose enable the block produces. The write strobe stores the bus data into one of two control registers. A mode input changes the write line into a combined direction line, for processors that give out one read/write signal and one data strobe.

An internal strobe is on only while all of its qualifiers hold. It turns on when the last qualifier becomes valid and turns off as soon as any one of them drops. Each pin goes through a two-flop synchronizer. The rising edge of a synchronized strobe performs its action once, however long the processor holds the access.

The FIFO side is a valid/ready stream. The block raises `fifo_ready` for exactly one clock cycle per read access. A word moves only if `fifo_valid` is high in that cycle. If the FIFO is empty, nothing moves and the block does not retry. The driver is still enabled, and the bus shows the last word read.

Top module: `bus_strobe_decoder`

## Requirements
- R1: After reset both control registers read zero, and `dout_oe` and `fifo_ready` are low.
- R2: In separate mode (`cfg_rw_combined`=0), a read access is `cs_a_n`=0, `cs_b`=1, `rd_n`=0 and `wr_n`=1. On the third rising clock edge after the last of these becomes valid, `dout` carries the popped FIFO word and `dout_oe` goes high. `dout_oe` stays high while the access lasts.
- R3: When any one read qualifier drops, `dout_oe` is still high after the second rising edge and is low after the third rising edge.
- R4: In separate mode, a write access is `cs_a_n`=0, `cs_b`=1, `wr_n`=0 and `rd_n`=1. It stores `din` into control register `addr`: 0 selects `ctrl0` and 1 selects `ctrl1`. The other register keeps its value.
- R5: One access acts once. However long it is held, it gives one `fifo_ready` pulse one cycle wide, or one register load.
- R6: If either chip select is not valid, no strobe forms. There is no pop, no load and no output enable.
- R7: In separate mode, if `rd_n` and `wr_n` are low together, neither strobe forms.
- R8: In combined mode (`cfg_rw_combined`=1), `wr_n` is the direction line and `rd_n` is the active-low data strobe. With both selects valid and `rd_n`=0, a high direction line is a read and a low direction line is a write.
- R9: A read access that finds `fifo_valid` low transfers no word. `dout_oe` still goes high and `dout` keeps the last word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rw_combined | input | 1 | 1: `wr_n` is the read/write direction line and `rd_n` is the data strobe |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| rd_n | input | 1 | Read line, active low (data strobe in combined mode) |
| wr_n | input | 1 | Write line, active low (direction line in combined mode) |
| addr | input | 1 | Control register select for writes |
| din | input | DW | Bus write data |
| fifo_valid | input | 1 | FIFO has a word |
| fifo_data | input | DW | FIFO head word |
| fifo_ready | output | 1 | One-cycle pop request |
| dout | output | DW | Read data toward the bus driver |
| dout_oe | output | 1 | Bus driver enable |
| ctrl0 | output | DW | Control register 0 |
| ctrl1 | output | DW | Control register 1 |

## Verification
The bench drops each read qualifier in turn. It samples on both sides of the third edge after the drop, so a decoder that keeps the strobe until every qualifier is gone, or that adds an extra stage, is caught. Long held accesses are counted against FIFO pops: a level-triggered design would drain several words or reload a register several times. Accesses with only one chip select valid, and with both direction lines low, must leave the registers and the FIFO alone; a decoder that ignores a qualifier would pop or load there. In combined mode a write uses both lines low, which separate mode rejects, so a design that ignores the mode input fails. An empty-FIFO read must hold the old word, which shows up a design that loads data without checking `fifo_valid`.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef struct packed {
    logic cs_a_n;
    logic cs_b;
    logic rd_n;
    logic wr_n;
    logic addr;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_a_n: 1'b1, cs_b: 1'b0, rd_n: 1'b1, wr_n: 1'b1, addr: 1'b0};
  localparam int PINS_W = $bits(pins_t);
endpackage

// File: rtl/bsd_sync.sv
module bsd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[0] <= RST_VAL;
          else        st[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) st[i] <= RST_VAL;
          else        st[i] <= st[i-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/bsd_decode.sv
module bsd_decode
  import bsd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  combined,
  input  pins_t p,
  output logic  rd_lvl,
  output logic  wr_lvl,
  output logic  rd_q,
  output logic  rd_rise,
  output logic  wr_rise
);
  logic sel, strobe;
  logic wr_q;

  assign sel    = !p.cs_a_n && p.cs_b;
  assign strobe = !p.rd_n;

  always_comb begin
    if (combined) begin
      rd_lvl = sel && strobe && p.wr_n;
      wr_lvl = sel && strobe && !p.wr_n;
    end else begin
      rd_lvl = sel && !p.rd_n && p.wr_n;
      wr_lvl = sel && !p.wr_n && p.rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_lvl;
      wr_q <= wr_lvl;
    end

  assign rd_rise = rd_lvl && !rd_q;
  assign wr_rise = wr_lvl && !wr_q;

  // a missing select keeps both registered strobes off
  assert_no_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p.cs_a_n || !p.cs_b) |=> (!rd_q && !wr_q));

  // conflicting direction lines in separate mode form nothing
  assert_conflict_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!combined && !p.rd_n && !p.wr_n) |=> (!rd_q && !wr_q));

  // a write edge is a single-cycle event
  assert_one_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> !wr_rise);
endmodule

// File: rtl/bsd_regs.sv
module bsd_regs #(
  parameter int DW = 10,
  parameter int NUM_REGS = 2,
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [SEL_W-1:0]             sel,
  input  logic [DW-1:0]                data,
  output logic [NUM_REGS-1:0][DW-1:0]  regs
);
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                              regs[g] <= '0;
        else if (load && (sel == SEL_W'(g)))     regs[g] <= data;
    end
  endgenerate

  // registers move only on a load pulse
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(regs));
endmodule

// File: rtl/bsd_rdport.sv
module bsd_rdport #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_req,
  input  logic          rd_active,
  input  logic          fifo_valid,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_ready,
  output logic [DW-1:0] dout,
  output logic          dout_oe
);
  assign fifo_ready = pop_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= rd_active;
      if (fifo_ready && fifo_valid) dout <= fifo_data;
    end

  assert_oe_after_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && fifo_valid) |=> dout_oe);

  assert_single_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |=> !fifo_ready);

  assert_empty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready && !fifo_valid) |=> $stable(dout));
endmodule

// File: rtl/bus_strobe_decoder.sv
module bus_strobe_decoder
  import bsd_pkg::*;
#(
  parameter int DW = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rw_combined,
  input  logic          cs_a_n,
  input  logic          cs_b,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          addr,
  input  logic [DW-1:0] din,
  input  logic          fifo_valid,
  input  logic [DW-1:0] fifo_data,
  output logic          fifo_ready,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic [DW-1:0] ctrl0,
  output logic [DW-1:0] ctrl1
);
  localparam int NUM_REGS = 2;

  pins_t raw, pins_s;
  logic [DW-1:0] din_s;
  logic rd_lvl, wr_lvl, rd_q, rd_rise, wr_rise;
  logic [NUM_REGS-1:0][DW-1:0] regs;

  assign raw = '{cs_a_n: cs_a_n, cs_b: cs_b, rd_n: rd_n, wr_n: wr_n, addr: addr};

  bsd_sync #(.W(PINS_W), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync_pins (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(pins_s));

  bsd_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s));

  bsd_decode u_dec (
    .clk(clk), .rst_n(rst_n), .combined(cfg_rw_combined), .p(pins_s),
    .rd_lvl(rd_lvl), .wr_lvl(wr_lvl), .rd_q(rd_q),
    .rd_rise(rd_rise), .wr_rise(wr_rise));

  bsd_regs #(.DW(DW), .NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(wr_rise), .sel(pins_s.addr),
    .data(din_s), .regs(regs));

  bsd_rdport #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .pop_req(rd_rise), .rd_active(rd_lvl),
    .fifo_valid(fifo_valid), .fifo_data(fifo_data),
    .fifo_ready(fifo_ready), .dout(dout), .dout_oe(dout_oe));

  assign ctrl0 = regs[0];
  assign ctrl1 = regs[1];

  // the bus driver and a register load never overlap
  assert_dir_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |-> !dout_oe || !rd_q);

  // register contents stay at their reset value until the first load
  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ctrl0 == '0 && ctrl1 == '0));
endmodule

// File: tb/bus_strobe_decoder_test.sv
module bus_strobe_decoder_test;
  localparam int DW = 10;
  localparam time CLK_P = 20ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rw_combined = 1'b0;
  logic cs_a_n = 1'b1, cs_b = 1'b0, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0;
  logic [DW-1:0] din = '0;
  logic fifo_valid = 1'b1;
  logic [DW-1:0] fifo_word = 10'h011;
  logic fifo_ready, dout_oe;
  logic [DW-1:0] dout, ctrl0, ctrl1;

  int checks = 0, fails = 0, pops = 0;
  bit done = 0;
  logic [DW-1:0] expq[$];
  logic [DW-1:0] last_rd = '0;
  logic [DW-1:0] exp_c0 = '0, exp_c1 = '0;

  always #(CLK_P/2) clk = ~clk;

  bus_strobe_decoder #(.DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_rw_combined(cfg_rw_combined),
    .cs_a_n(cs_a_n), .cs_b(cs_b), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .fifo_valid(fifo_valid), .fifo_data(fifo_word),
    .fifo_ready(fifo_ready), .dout(dout), .dout_oe(dout_oe),
    .ctrl0(ctrl0), .ctrl1(ctrl1));

  // FIFO model: advance head on each transfer
  always @(posedge clk)
    if (fifo_ready && fifo_valid) begin
      pops <= pops + 1;
      fifo_word <= fifo_word + 10'h03B;
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare read data against scoreboard when the driver turns on
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && dout_oe && !oe_prev) begin
      if (expq.size() == 0) chk(1'b0, "R2 unexpected read", dout, 0);
      else begin
        logic [DW-1:0] e;
        e = expq.pop_front();
        chk(dout == e, "R2/R9 read data", dout, e);
      end
    end
    oe_prev = dout_oe;
  end

  task automatic idle_bus();
    cs_a_n = 1'b1; cs_b = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drop: 0 cs_a_n, 1 cs_b, 2 strobe line
  task automatic do_read(input int drop, input string req);
    int p0;
    @(negedge clk);
    p0 = pops;
    if (fifo_valid) begin expq.push_back(fifo_word); last_rd = fifo_word; end
    else expq.push_back(last_rd);
    cs_a_n = 1'b0; cs_b = 1'b1; rd_n = 1'b0; wr_n = 1'b1;
    wait_n(8);
    chk(dout_oe == 1'b1, {req, " R2 oe held"}, dout_oe, 1);
    chk(pops - p0 == (fifo_valid ? 1 : 0), {req, " R5 one pop"}, pops - p0, fifo_valid ? 1 : 0);
    case (drop)
      0: cs_a_n = 1'b1;
      1: cs_b = 1'b0;
      default: rd_n = 1'b1;
    endcase
    wait_n(2);
    chk(dout_oe == 1'b1, {req, " R3 oe before third edge"}, dout_oe, 1);
    wait_n(1);
    chk(dout_oe == 1'b0, {req, " R3 oe off at third edge"}, dout_oe, 0);
    idle_bus();
    wait_n(4);
  endtask

  task automatic do_write(input logic a, input logic [DW-1:0] d, input bit effective);
    @(negedge clk);
    addr = a; din = d;
    cs_a_n = 1'b0; cs_b = 1'b1;
    wr_n = 1'b0;
    rd_n = cfg_rw_combined ? 1'b0 : 1'b1;
    wait_n(8);
    idle_bus();
    wait_n(5);
    if (effective) begin
      if (a) exp_c1 = d; else exp_c0 = d;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int p0;
    wait_n(3);
    chk(ctrl0 == 0, "R1 ctrl0 reset", ctrl0, 0);
    chk(ctrl1 == 0, "R1 ctrl1 reset", ctrl1, 0);
    chk(dout_oe == 0, "R1 oe reset", dout_oe, 0);
    chk(fifo_ready == 0, "R1 ready reset", fifo_ready, 0);
    rst_n = 1'b1;
    wait_n(3);

    // R4 writes to both registers
    do_write(1'b0, 10'h155, 1);
    chk(ctrl0 == exp_c0, "R4 ctrl0 load", ctrl0, exp_c0);
    chk(ctrl1 == exp_c1, "R4 ctrl1 untouched", ctrl1, exp_c1);
    do_write(1'b1, 10'h2AA, 1);
    chk(ctrl1 == exp_c1, "R4 ctrl1 load", ctrl1, exp_c1);
    chk(ctrl0 == exp_c0, "R4 ctrl0 untouched", ctrl0, exp_c0);

    // R2/R3/R5 reads, each qualifier dropped in turn
    do_read(0, "R3 drop cs_a_n");
    do_read(1, "R3 drop cs_b");
    do_read(2, "R3 drop rd_n");

    // R6 only one select valid
    p0 = pops;
    @(negedge clk); cs_a_n = 1'b0; cs_b = 1'b0; rd_n = 1'b0;
    wait_n(6);
    chk(dout_oe == 0, "R6 no oe with cs_b invalid", dout_oe, 0);
    chk(pops == p0, "R6 no pop", pops, p0);
    idle_bus(); wait_n(4);
    @(negedge clk); cs_a_n = 1'b1; cs_b = 1'b1; wr_n = 1'b0; addr = 1'b0; din = 10'h0F0;
    wait_n(6); idle_bus(); wait_n(4);
    chk(ctrl0 == exp_c0, "R6 no load with cs_a_n invalid", ctrl0, exp_c0);

    // R7 both direction lines low
    p0 = pops;
    @(negedge clk); cs_a_n = 1'b0; cs_b = 1'b1; rd_n = 1'b0; wr_n = 1'b0; addr = 1'b1; din = 10'h07E;
    wait_n(6);
    chk(dout_oe == 0, "R7 no oe on conflict", dout_oe, 0);
    idle_bus(); wait_n(4);
    chk(pops == p0, "R7 no pop on conflict", pops, p0);
    chk(ctrl1 == exp_c1, "R7 no load on conflict", ctrl1, exp_c1);

    // R8 combined mode
    cfg_rw_combined = 1'b1;
    wait_n(2);
    do_read(2, "R8 combined read");
    do_write(1'b0, 10'h3C3, 1);
    chk(ctrl0 == exp_c0, "R8 combined write", ctrl0, exp_c0);
    cfg_rw_combined = 1'b0;
    wait_n(2);

    // R9 empty FIFO
    fifo_valid = 1'b0;
    do_read(2, "R9 empty read");
    fifo_valid = 1'b1;

    wait_n(4);
    chk(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule